// File: doc/BRIEF.md
# Bit-Serial Register Access Slave

This block is the device-side end of a four-wire, bit-banged register link. A host controls an active-low clear line, a strobe and a serial input, and reads a serial output. Through them it reaches a small bank of 16-bit registers. All host wires are asynchronous to the local clock. The block samples them through two-flop synchronizers and detects strobe edges in its own clock domain. The host must hold each strobe level for at least three local clocks.

A transaction starts with a clear pulse. An 8-bit header follows, most significant bit first: the top bit selects read (1) or write (0), and the lower seven bits give the register address. Then 16 data bits move, most significant bit first. Write data is captured on rising strobe edges. Read data is shifted out so that each bit is stable once a strobe pulse has finished.

The bank holds two read-only identification words and a set of writable control words: function enables, GPIO enables and GPIO directions. The control words also drive the block's outputs.

Top module: `serial_regbank`

## Requirements
- R1: A low level on the clear line (`clr_n_i`) aborts any partial frame and resets the bit counter. The next rising strobe edges start a new header.
- R2: The header is 8 bits, captured from `sdi_i` on rising strobe edges, most significant bit first. Bit 7 is the read flag (1 = read) and bits 6..0 are the register address.
- R3: A write captures 16 data bits from `sdi_i` on the rising strobe edges after the header, most significant bit first. The target register changes only after the 16th bit has arrived, so a frame cut short by a clear leaves it unchanged.
- R4: On a read, `sdo_o` carries data bit 15 once the first data strobe pulse has completed, and each later pulse advances one bit toward bit 0. Outside the data phase of a read, `sdo_o` is low.
- R5: Address 0x00 reads as the platform word: bits 15..8 equal parameter `PLAT_HI` and bits 7..0 equal the manufacturer code 0x01.
- R6: Address 0x01 reads as the firmware word, with build in bits 15..12, major in bits 11..8 (always 0), minor in bits 7..4 and patch in bits 3..0.
- R7: The control words are readable and writable, and each appears on its output slice (word i at bits i*16 and up):
  - function enables at 0x08..0x09 on `func_en_o`;
  - GPIO enables at 0x10..0x12 on `gpio_en_o`;
  - GPIO directions at 0x18..0x1A on `gpio_dir_o`.
- R8: Writes to addresses 0x00 and 0x01 are ignored, and those words keep their values.
- R9: A read of an unmapped address returns 0x0000. A write to an unmapped address changes no register.
- R10: While `en_i` is low, strobe edges are ignored and `sdo_o` is held low.
- R11: After reset, all control words are 0 and `sdo_o` is low.
- R12: Once a frame has taken all 24 strobe edges, further strobe edges are ignored until the next clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Link enable (asynchronous) |
| clr_n_i | input | 1 | Active-low frame clear (asynchronous) |
| strb_i | input | 1 | Host strobe (asynchronous) |
| sdi_i | input | 1 | Serial data from the host |
| sdo_o | output | 1 | Serial data to the host |
| func_en_o | output | N_FUNC*16 | Function-enable words |
| gpio_en_o | output | N_GPIO*16 | GPIO-enable words |
| gpio_dir_o | output | N_GPIO*16 | GPIO-direction words |

## Verification
The assertions assume the host wires change slowly enough that every strobe level survives the synchronizers and produces exactly one detected rising edge. They also assume the clear line is low long enough to be seen. The stimulus holds every level of strobe, clear and data for six local clocks and changes data only while strobe is low. It changes the enable line only between frames, followed by a settling wait.

// File: rtl/serial_regbank.sv
module serial_regbank #(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 16,
  parameter int N_FUNC = 2,
  parameter int N_GPIO = 3,
  parameter int A_PLAT = 0,
  parameter int A_FW = 1,
  parameter int A_FUNC = 8,
  parameter int A_GPEN = 16,
  parameter int A_GPDIR = 24,
  parameter logic [7:0] PLAT_HI = 8'h00,
  parameter logic [7:0] MFG_CODE = 8'h01,
  parameter logic [3:0] FW_BUILD = 4'h0,
  parameter logic [3:0] FW_MINOR = 4'h0,
  parameter logic [3:0] FW_PATCH = 4'h0
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     en_i,
  input  logic                     clr_n_i,
  input  logic                     strb_i,
  input  logic                     sdi_i,
  output logic                     sdo_o,
  output logic [N_FUNC*DATA_W-1:0] func_en_o,
  output logic [N_GPIO*DATA_W-1:0] gpio_en_o,
  output logic [N_GPIO*DATA_W-1:0] gpio_dir_o
);
  localparam int HDR_W = ADDR_W + 1;
  localparam int FRAME = HDR_W + DATA_W;
  localparam int CW = $clog2(FRAME + 1);
  localparam logic [CW-1:0] C_HDR = CW'(HDR_W);
  localparam logic [CW-1:0] C_END = CW'(FRAME);
  localparam logic [DATA_W-1:0] PLAT_WORD = DATA_W'({PLAT_HI, MFG_CODE});
  localparam logic [DATA_W-1:0] FW_WORD = DATA_W'({FW_BUILD, 4'h0, FW_MINOR, FW_PATCH});

  logic [3:0] sy0, sy1;
  logic       strb_d;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sy0 <= '0;
      sy1 <= '0;
      strb_d <= 1'b0;
    end else begin
      sy0 <= {en_i, clr_n_i, strb_i, sdi_i};
      sy1 <= sy0;
      strb_d <= sy1[1];
    end

  wire en_s  = sy1[3];
  wire clr_s = sy1[2];
  wire strb_s = sy1[1];
  wire sdi_s = sy1[0];

  logic [CW-1:0]     cnt;
  logic [HDR_W-1:0]  hdr;
  logic [DATA_W-1:0] wsh, rsh, rd_val;
  logic [DATA_W-1:0] func_q [N_FUNC];
  logic [DATA_W-1:0] gpen_q [N_GPIO];
  logic [DATA_W-1:0] gpdir_q [N_GPIO];

  wire step = strb_s & ~strb_d & en_s & clr_s & (cnt != C_END);
  wire [ADDR_W-1:0] rd_addr = {hdr[ADDR_W-2:0], sdi_s};
  wire [ADDR_W-1:0] wr_addr = hdr[ADDR_W-1:0];
  wire [DATA_W-1:0] wdata = {wsh[DATA_W-2:0], sdi_s};
  wire wr_go = step && (cnt == C_END - 1'b1) && !hdr[ADDR_W];

  always_comb begin
    rd_val = '0;
    if (rd_addr == ADDR_W'(A_PLAT)) rd_val = PLAT_WORD;
    if (rd_addr == ADDR_W'(A_FW)) rd_val = FW_WORD;
    for (int i = 0; i < N_FUNC; i++)
      if (rd_addr == ADDR_W'(A_FUNC + i)) rd_val = func_q[i];
    for (int i = 0; i < N_GPIO; i++) begin
      if (rd_addr == ADDR_W'(A_GPEN + i)) rd_val = gpen_q[i];
      if (rd_addr == ADDR_W'(A_GPDIR + i)) rd_val = gpdir_q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt <= '0;
      hdr <= '0;
      wsh <= '0;
      rsh <= '0;
    end else if (!clr_s) begin
      cnt <= '0;
      rsh <= '0;
    end else if (step) begin
      cnt <= cnt + 1'b1;
      if (cnt < C_HDR) hdr <= {hdr[ADDR_W-1:0], sdi_s};
      if (cnt == C_HDR - 1'b1) rsh <= hdr[ADDR_W-1] ? rd_val : '0;
      else if (cnt > C_HDR && hdr[ADDR_W]) rsh <= {rsh[DATA_W-2:0], 1'b0};
      if (cnt >= C_HDR) wsh <= {wsh[DATA_W-2:0], sdi_s};
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < N_FUNC; i++) func_q[i] <= '0;
      for (int i = 0; i < N_GPIO; i++) begin
        gpen_q[i] <= '0;
        gpdir_q[i] <= '0;
      end
    end else if (wr_go) begin
      for (int i = 0; i < N_FUNC; i++)
        if (wr_addr == ADDR_W'(A_FUNC + i)) func_q[i] <= wdata;
      for (int i = 0; i < N_GPIO; i++) begin
        if (wr_addr == ADDR_W'(A_GPEN + i)) gpen_q[i] <= wdata;
        if (wr_addr == ADDR_W'(A_GPDIR + i)) gpdir_q[i] <= wdata;
      end
    end

  assign sdo_o = en_s & rsh[DATA_W-1];

  for (genvar g = 0; g < N_FUNC; g++) begin : g_func
    assign func_en_o[g*DATA_W +: DATA_W] = func_q[g];
  end
  for (genvar g = 0; g < N_GPIO; g++) begin : g_gpio
    assign gpio_en_o[g*DATA_W +: DATA_W] = gpen_q[g];
    assign gpio_dir_o[g*DATA_W +: DATA_W] = gpdir_q[g];
  end
endmodule

// File: rtl/serial_regbank_chk.sv
module serial_regbank_chk #(
  parameter int CW = 5,
  parameter int FRAME = 24,
  parameter int HDR_LEN = 8,
  parameter int CTL_W = 128
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en_s,
  input logic             clr_s,
  input logic             step,
  input logic             rd_flag,
  input logic [CW-1:0]    cnt,
  input logic             sdo_o,
  input logic [CTL_W-1:0] ctl
);
  a_r1_clear_zeroes_count: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_s |=> cnt == '0);

  a_r12_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(FRAME));

  a_r10_disabled_holds_count: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_s && clr_s) |=> $stable(cnt));

  a_r3_ctl_changes_at_frame_end: assert property (@(posedge clk) disable iff (!rst_n)
    !(step && cnt == CW'(FRAME - 1)) |=> $stable(ctl));

  a_r4_sdo_only_in_read_data: assert property (@(posedge clk) disable iff (!rst_n)
    sdo_o |-> (rd_flag && cnt >= CW'(HDR_LEN)));
endmodule

bind serial_regbank serial_regbank_chk #(
  .CW(CW), .FRAME(FRAME), .HDR_LEN(HDR_W),
  .CTL_W((N_FUNC + 2 * N_GPIO) * DATA_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .en_s(en_s), .clr_s(clr_s), .step(step),
  .rd_flag(hdr[ADDR_W]), .cnt(cnt), .sdo_o(sdo_o),
  .ctl({func_en_o, gpio_en_o, gpio_dir_o})
);

// File: tb/serial_regbank_tb_top.sv
module serial_regbank_tb_top;
  localparam int H = 6;
  logic clk = 1'b0, rst_n = 1'b0;
  logic en = 1'b1, clr_n = 1'b1, strb = 1'b0, sdi = 1'b0;
  logic sdo;
  logic [31:0] func_en;
  logic [47:0] gpio_en, gpio_dir;
  int errors = 0, checks = 0;
  logic [15:0] mdl [128];

  always #4 clk = ~clk;

  serial_regbank #(.PLAT_HI(8'hA5), .FW_BUILD(4'h2), .FW_MINOR(4'h3), .FW_PATCH(4'h7)) dut_i (
    .clk(clk), .rst_n(rst_n), .en_i(en), .clr_n_i(clr_n), .strb_i(strb), .sdi_i(sdi),
    .sdo_o(sdo), .func_en_o(func_en), .gpio_en_o(gpio_en), .gpio_dir_o(gpio_dir));

  function automatic bit is_ctl(int a);
    return a == 8 || a == 9 || (a >= 16 && a <= 18) || (a >= 24 && a <= 26);
  endfunction

  function automatic logic [15:0] exp_rd(int a);
    if (a == 0) return 16'hA501;
    if (a == 1) return 16'h2037;
    if (is_ctl(a)) return mdl[a];
    return 16'h0000;
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic waith();
    repeat (H) @(negedge clk);
  endtask

  task automatic start_frame(bit rd, logic [6:0] a);
    logic [7:0] h;
    h = {rd, a};
    strb = 1'b0; clr_n = 1'b0; waith(); clr_n = 1'b1; waith();
    for (int i = 7; i >= 0; i--) begin
      strb = 1'b0; sdi = h[i]; waith();
      strb = 1'b1; waith();
    end
    strb = 1'b0; waith();
  endtask

  task automatic send_bits(logic [15:0] d, int n);
    for (int i = 15; i > 15 - n; i--) begin
      sdi = d[i]; strb = 1'b1; waith();
      strb = 1'b0; waith();
    end
  endtask

  task automatic wr(logic [6:0] a, logic [15:0] d);
    start_frame(1'b0, a);
    send_bits(d, 16);
    strb = 1'b1; waith();
    if (en && is_ctl(a)) mdl[a] = d;
  endtask

  task automatic rd(logic [6:0] a, output logic [15:0] v);
    start_frame(1'b1, a);
    v = '0;
    for (int i = 15; i >= 0; i--) begin
      strb = 1'b1; waith();
      strb = 1'b0; waith();
      v[i] = sdo;
    end
    strb = 1'b1; waith();
  endtask

  task automatic check_outs(string req);
    check(req, {32'h0, func_en}, {32'h0, mdl[9], mdl[8]});
    check(req, {16'h0, gpio_en}, {16'h0, mdl[18], mdl[17], mdl[16]});
    check(req, {16'h0, gpio_dir}, {16'h0, mdl[26], mdl[25], mdl[24]});
  endtask

  function automatic logic [6:0] pick_addr();
    case ($urandom % 12)
      0: return 7'h08;  1: return 7'h09;  2: return 7'h10;  3: return 7'h11;
      4: return 7'h12;  5: return 7'h18;  6: return 7'h19;  7: return 7'h1A;
      8: return 7'h00;  9: return 7'h01;
      default: return 7'($urandom % 128);
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [15:0] v;
    void'($urandom(32'd1234));
    for (int i = 0; i < 128; i++) mdl[i] = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R11 reset sdo", {63'h0, sdo}, 64'h0);
    check_outs("R11 reset control words");

    rd(7'h00, v); check("R5 platform word", {48'h0, v}, {48'h0, 16'hA501});
    rd(7'h01, v); check("R6 firmware word", {48'h0, v}, {48'h0, 16'h2037});

    wr(7'h00, 16'hFFFF); wr(7'h01, 16'h1234);
    rd(7'h00, v); check("R8 platform write ignored", {48'h0, v}, {48'h0, 16'hA501});
    rd(7'h01, v); check("R8 firmware write ignored", {48'h0, v}, {48'h0, 16'h2037});

    wr(7'h10, 16'h8001); wr(7'h11, 16'h7FFE);
    rd(7'h10, v); check("R2 R4 address decode 0x10", {48'h0, v}, {48'h0, 16'h8001});
    rd(7'h11, v); check("R2 R4 address decode 0x11", {48'h0, v}, {48'h0, 16'h7FFE});
    check_outs("R7 outputs follow writes");

    wr(7'h40, 16'hBEEF);
    rd(7'h40, v); check("R9 unmapped read zero", {48'h0, v}, 64'h0);
    check_outs("R9 unmapped write no effect");

    start_frame(1'b0, 7'h08);
    send_bits(16'hFFFF, 10);
    wr(7'h09, 16'h5A5A);
    rd(7'h08, v); check("R1 R3 partial frame discarded", {48'h0, v}, {48'h0, mdl[8]});
    rd(7'h09, v); check("R1 frame after clear", {48'h0, v}, {48'h0, 16'h5A5A});

    start_frame(1'b0, 7'h18);
    send_bits(16'hC3A5, 16);
    send_bits(16'hFFFF, 4);
    mdl[24] = 16'hC3A5;
    rd(7'h18, v); check("R12 extra strobes ignored", {48'h0, v}, {48'h0, 16'hC3A5});

    en = 1'b0; repeat (4) @(negedge clk);
    wr(7'h12, 16'h0F0F);
    rd(7'h18, v); check("R10 sdo low while disabled", {48'h0, v}, 64'h0);
    en = 1'b1; repeat (4) @(negedge clk);
    rd(7'h12, v); check("R10 write ignored while disabled", {48'h0, v}, {48'h0, mdl[18]});

    for (int k = 0; k < 60; k++) begin
      logic [6:0] a;
      logic [15:0] d;
      a = pick_addr();
      d = 16'($urandom);
      if ($urandom % 3 != 0) wr(a, d);
      a = pick_addr();
      rd(a, v);
      check("R4 R7 random read", {48'h0, v}, {48'h0, exp_rd(int'(a))});
      if (k % 10 == 0) check_outs("R7 random outputs");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule